// File: doc/BRIEF.md
# Re-armable Mailbox Command-Echo Responder

This block plays the far side of a four-register mailbox during integration tests. It sits on the peer-side register port of the mailbox and reads the host-to-peer flag register every cycle, waiting for the doorbell bit. When the doorbell rises, it reads the host-to-peer command word. It writes that word unchanged into the peer-to-host command register, then writes an acknowledge value into the peer-to-host flag register. It counts each finished exchange on `ack_count`.

It never clears the doorbell. After acknowledging, it keeps reading the host-to-peer flag until an outside agent (normally the testbench acting as host) has cleared the doorbell bit, and only then does it go back to waiting. Each exchange therefore has a clear lifecycle: ring, echo, acknowledge, host clears, re-arm.

The machine has five states. `ST_POLL` reads the host flag and moves to `ST_FETCH` when the doorbell is set; otherwise it stays. `ST_FETCH` reads the host command and always moves to `ST_ECHO`. `ST_ECHO` writes the peer command and always moves to `ST_ACK`. `ST_ACK` writes the peer flag, bumps the counter and always moves to `ST_DRAIN`. `ST_DRAIN` reads the host flag and moves back to `ST_POLL` only when the doorbell reads low; otherwise it stays.

Top module: `mbx_echo_responder`

## Requirements
- R1: While reset is held and on the first cycle after it, `ack_count` is 0, `mb_wr` is 0, and the block reads register index 1 (`mb_rd`=1, `mb_addr`=1).
- R2: Register index 1 is the host-to-peer flag, and the doorbell is its bit 0. While bit 0 reads 0 the block keeps reading index 1 and issues no write, whatever the other bits hold.
- R3: One cycle after the cycle in which the flag read returns bit 0 set, the block reads index 0 (host-to-peer command). In the next cycle it writes the value read to index 2 (peer-to-host command), unchanged.
- R4: In the cycle right after the index-2 write, the block writes 0x1 to index 3 (peer-to-host flag).
- R5: After the index-3 write, the block starts no new exchange while the doorbell reads 1. It keeps reading index 1, and only a flag read with bit 0 at 0 re-arms it.
- R6: The block never writes index 0 or index 1. Every write goes to index 2 or 3.
- R7: `ack_count` rises by exactly one in the cycle after each index-3 write and holds at all other times. It is CNT_W bits wide (16 by default) and wraps from all ones to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mb_addr | output | 2 | Mailbox register index: 0 host cmd, 1 host flag, 2 peer cmd, 3 peer flag |
| mb_rd | output | 1 | Read strobe for the current index |
| mb_wr | output | 1 | Write strobe for the current index |
| mb_wdata | output | DW | Write data |
| mb_rdata | input | DW | Read data for `mb_addr`, valid in the same cycle |
| ack_count | output | CNT_W | Count of completed exchanges, wrapping |

## Verification
A wrong state shows at the register port in the very next cycle, because every state drives its own index and strobe. If the machine leaves `ST_DRAIN` too early, a second index-2 write appears while the doorbell is still held, and no expected command is queued for it. A lost or stale command latch shows as an index-2 value that differs from the word the host placed one cycle before. A counter that is off shows one cycle after the index-3 write, and the wrap is exercised by running more exchanges than the counter can hold.

// File: rtl/mbx_echo_pkg.sv
package mbx_echo_pkg;

    typedef enum logic [2:0] {
        ST_POLL  = 3'd0,
        ST_FETCH = 3'd1,
        ST_ECHO  = 3'd2,
        ST_ACK   = 3'd3,
        ST_DRAIN = 3'd4
    } echo_state_t;

    localparam int MBX_AW = 2;

    localparam logic [MBX_AW-1:0] IDX_H2P_CMD  = 2'd0;
    localparam logic [MBX_AW-1:0] IDX_H2P_FLAG = 2'd1;
    localparam logic [MBX_AW-1:0] IDX_P2H_CMD  = 2'd2;
    localparam logic [MBX_AW-1:0] IDX_P2H_FLAG = 2'd3;

endpackage

// File: rtl/mbx_cmd_latch.sv
module mbx_cmd_latch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/mbx_ack_counter.sv
module mbx_ack_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (bump) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/mbx_echo_responder.sv
module mbx_echo_responder
    import mbx_echo_pkg::*;
#(
    parameter int          DW           = 32,
    parameter int          CNT_W        = 16,
    parameter int          DOORBELL_BIT = 0,
    parameter int unsigned ACK_VALUE    = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [MBX_AW-1:0]    mb_addr,
    output logic                 mb_rd,
    output logic                 mb_wr,
    output logic [DW-1:0]        mb_wdata,
    input  logic [DW-1:0]        mb_rdata,
    output logic [CNT_W-1:0]     ack_count
);

    localparam logic [DW-1:0] ACK_WORD = DW'(ACK_VALUE);

    echo_state_t state;
    logic        doorbell;
    logic        cmd_load;
    logic        ack_bump;
    logic [DW-1:0] cmd_q;

    assign doorbell = mb_rdata[DOORBELL_BIT];

    // State register and transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_POLL;
        end else begin
            unique case (state)
                ST_POLL:  if (doorbell)  state <= ST_FETCH;
                ST_FETCH: state <= ST_ECHO;
                ST_ECHO:  state <= ST_ACK;
                ST_ACK:   state <= ST_DRAIN;
                ST_DRAIN: if (!doorbell) state <= ST_POLL;
                default:  state <= ST_POLL;
            endcase
        end
    end

    // Port drive for each state
    always_comb begin
        mb_addr  = IDX_H2P_FLAG;
        mb_rd    = 1'b0;
        mb_wr    = 1'b0;
        mb_wdata = '0;
        cmd_load = 1'b0;
        ack_bump = 1'b0;
        unique case (state)
            ST_POLL, ST_DRAIN: begin
                mb_addr = IDX_H2P_FLAG;
                mb_rd   = 1'b1;
            end
            ST_FETCH: begin
                mb_addr  = IDX_H2P_CMD;
                mb_rd    = 1'b1;
                cmd_load = 1'b1;
            end
            ST_ECHO: begin
                mb_addr  = IDX_P2H_CMD;
                mb_wr    = 1'b1;
                mb_wdata = cmd_q;
            end
            ST_ACK: begin
                mb_addr  = IDX_P2H_FLAG;
                mb_wr    = 1'b1;
                mb_wdata = ACK_WORD;
                ack_bump = 1'b1;
            end
            default: begin
                mb_addr = IDX_H2P_FLAG;
            end
        endcase
    end

    mbx_cmd_latch #(.W(DW)) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cmd_load),
        .d     (mb_rdata),
        .q     (cmd_q)
    );

    mbx_ack_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (ack_bump),
        .count (ack_count)
    );

endmodule

// File: rtl/mbx_echo_checker.sv
module mbx_echo_checker
    import mbx_echo_pkg::*;
#(
    parameter int          DW           = 32,
    parameter int          CNT_W        = 16,
    parameter int          DOORBELL_BIT = 0,
    parameter int unsigned ACK_VALUE    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MBX_AW-1:0] mb_addr,
    input  logic              mb_rd,
    input  logic              mb_wr,
    input  logic [DW-1:0]     mb_wdata,
    input  logic [DW-1:0]     mb_rdata,
    input  logic [CNT_W-1:0]  ack_count
);

    logic flag_wr, cmd_rd, flag_rd, blocked;

    assign flag_wr = mb_wr && (mb_addr == IDX_P2H_FLAG);
    assign cmd_rd  = mb_rd && (mb_addr == IDX_H2P_CMD);
    assign flag_rd = mb_rd && (mb_addr == IDX_H2P_FLAG);

    // Set by an acknowledge, cleared once the host flag reads low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked <= 1'b0;
        end else if (flag_wr) begin
            blocked <= 1'b1;
        end else if (flag_rd && !mb_rdata[DOORBELL_BIT]) begin
            blocked <= 1'b0;
        end
    end

    AST_QUIET_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !mb_rdata[DOORBELL_BIT]) |=> (flag_rd && !mb_wr)); // R2

    AST_ECHO_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rd |=> (mb_wr && mb_addr == IDX_P2H_CMD && mb_wdata == $past(mb_rdata))); // R3

    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_wr && mb_addr == IDX_P2H_CMD) |=> (flag_wr && mb_wdata == DW'(ACK_VALUE))); // R4

    AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> !cmd_rd); // R5

    AST_HOST_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        mb_wr |-> mb_addr[1]); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> (ack_count == $past(ack_count) + 1'b1)); // R7

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> $stable(ack_count)); // R7

endmodule

bind mbx_echo_responder mbx_echo_checker #(
    .DW           (DW),
    .CNT_W        (CNT_W),
    .DOORBELL_BIT (DOORBELL_BIT),
    .ACK_VALUE    (ACK_VALUE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mb_addr   (mb_addr),
    .mb_rd     (mb_rd),
    .mb_wr     (mb_wr),
    .mb_wdata  (mb_wdata),
    .mb_rdata  (mb_rdata),
    .ack_count (ack_count)
);

// File: tb/sim_mbx_echo_responder.sv
module sim_mbx_echo_responder;

    localparam int DW    = 32;
    localparam int CW    = 4;
    localparam int CMASK = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mb_addr;
    logic          mb_rd, mb_wr;
    logic [DW-1:0] mb_wdata, mb_rdata;
    logic [CW-1:0] ack_count;

    // Mailbox model: host side driven by the driver, peer side by the port
    logic [DW-1:0] h_cmd = '0, h_flag = '0, p_cmd, p_flag;

    int n_chk_d = 0, n_bad_d = 0, n_chk_m = 0, n_bad_m = 0;
    logic [DW-1:0] exp_q[$];

    always #10 clk = ~clk;

    mbx_echo_responder #(.DW(DW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .mb_addr(mb_addr), .mb_rd(mb_rd),
        .mb_wr(mb_wr), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata),
        .ack_count(ack_count)
    );

    always_comb begin
        case (mb_addr)
            2'd0:    mb_rdata = h_cmd;
            2'd1:    mb_rdata = h_flag;
            2'd2:    mb_rdata = p_cmd;
            default: mb_rdata = p_flag;
        endcase
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            p_cmd  <= '0;
            p_flag <= '0;
        end else if (mb_wr && mb_addr == 2'd2) begin
            p_cmd <= mb_wdata;
        end else if (mb_wr && mb_addr == 2'd3) begin
            p_flag <= mb_wdata;
        end
    end

    task automatic dchk(input bit ok, input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
        n_chk_d++;
        if (!ok) begin
            n_bad_d++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mchk(input bit ok, input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
        n_chk_m++;
        if (!ok) begin
            n_bad_m++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected commands as the design writes them
    int exp_cnt = 0;
    bit pend_flag = 0, pend_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend_cnt) begin
                mchk(ack_count == CW'(exp_cnt), "R7 count step", ack_count, exp_cnt);
                pend_cnt = 0;
            end
            if (pend_flag) begin
                mchk(mb_wr && mb_addr == 2'd3, "R4 flag write slot", {mb_wr, mb_addr}, 3'b111);
                mchk(mb_wdata == 32'h1, "R4 ack value", mb_wdata, 32'h1);
                exp_cnt   = (exp_cnt + 1) & CMASK;
                pend_cnt  = 1;
                pend_flag = 0;
            end else if (mb_wr) begin
                if (mb_addr == 2'd2) begin
                    if (exp_q.size() == 0) begin
                        mchk(0, "R5 unexpected echo", mb_wdata, 0);
                    end else begin
                        logic [DW-1:0] e;
                        e = exp_q.pop_front();
                        mchk(mb_wdata == e, "R3 echo value", mb_wdata, e);
                    end
                    pend_flag = 1;
                end else begin
                    mchk(0, "R6 write to wrong index", mb_addr, 2);
                end
            end
        end
    end

    // Driver: ring the doorbell, hold it, then clear it
    task automatic ring(input logic [DW-1:0] cmd, input logic [DW-1:0] fv, input int hold);
        @(negedge clk);
        exp_q.push_back(cmd);
        h_cmd  = cmd;
        h_flag = fv;
        @(negedge clk);
        dchk(mb_rd && mb_addr == 2'd0 && !mb_wr, "R3 fetch timing", {mb_rd, mb_addr}, 3'b100);
        repeat (3) @(negedge clk);
        for (int k = 0; k < hold; k++) begin
            h_cmd = cmd ^ 32'h5555_0000 ^ DW'(k);
            @(negedge clk);
        end
        dchk(mb_rd && mb_addr == 2'd1 && !mb_wr, "R5 still draining", {mb_rd, mb_addr}, 3'b101);
        h_flag = '0;
        @(negedge clk);
        dchk(mb_rd && mb_addr == 2'd1, "R5 re-armed poll", {mb_rd, mb_addr}, 3'b101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        dchk(ack_count == 0, "R1 count in reset", ack_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        dchk(ack_count == 0, "R1 count after reset", ack_count, 0);
        dchk(mb_rd && mb_addr == 2'd1, "R1 polling flag", {mb_rd, mb_addr}, 3'b101);
        dchk(!mb_wr, "R1 no write", mb_wr, 0);

        // R2: other flag bits set, doorbell clear -> nothing happens
        h_cmd  = 32'h1234_5678;
        h_flag = 32'hFFFF_FFFE;
        repeat (12) @(negedge clk);
        dchk(mb_rd && mb_addr == 2'd1 && !mb_wr, "R2 quiet poll", {mb_wr, mb_addr}, 1);
        dchk(ack_count == 0, "R2 no ack", ack_count, 0);
        h_flag = '0;

        ring(32'hA5A5_0001, 32'h1, 0);
        ring(32'hDEAD_BEEF, 32'hFFFF_FFFF, 15);    // R5 long hold, cmd changes
        dchk(ack_count == 2, "R5 single ack per ring", ack_count, 2);
        ring(32'h0, 32'h1, 3);
        for (int i = 0; i < 16; i++) begin
            ring(32'h0100_0000 * (i + 1) + DW'(i), 32'h1, i % 4);
        end
        dchk(ack_count == CW'(19), "R7 wrap", ack_count, 19 & CMASK);
        dchk(p_flag == 32'h1, "R4 peer flag holds ack", p_flag, 1);
        dchk(h_flag == 0 && exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk_d + n_chk_m, n_bad_d + n_bad_m);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk_d + n_chk_m + 1, n_bad_d + n_bad_m + 1);
        $finish;
    end

endmodule